// File: doc/BRIEF.md
# Divider Configuration Loader

This block holds the configuration of a frequency synthesizer's divider chain: a 9-bit feedback divide value, a 3-bit output divide code for each of two output banks, and a 2-bit selector for a test observation pin. The configuration can be written in two ways. The first way uses parallel pins that are captured by an active-low strobe. The second way uses a 17-bit shift register that is fed by a serial data line and a serial clock, and is committed by a serial load strobe. The dividers and the PLL that use these values are outside this block.

Every strobe and pin goes through a two-flop synchronizer into the system clock domain. Edges are detected there, so each action takes effect a fixed three clock edges after its input changes. After reset, the configuration takes the values on the parallel pins. Pins that are tied off on the board therefore set the start-up configuration. The test output is low in parallel mode. In serial mode it shows one of four sources, picked by the test-select bits.

Top module: `div_cfg_loader`

## Requirements
- R1: After reset is released, m_o, na_o and nb_o equal the parallel pin values, the test-select bits are 00, and test_o is low.
- R2: While par_load_ni is low, m_o, na_o and nb_o follow par_m_i, par_na_i and par_nb_i.
- R3: A rising edge of par_load_ni freezes the outputs. Later changes on the parallel pins have no effect until par_load_ni goes low again or a serial load occurs.
- R4: A rising edge of ser_clk_i with par_load_ni high shifts ser_data_i into bit 0 of the 17-bit shift register. The first bit shifted in ends up in bit 16. Bits 16:15 are the test-select bits (first-in is the upper bit), bits 14:12 are nb, bits 11:9 are na, and bits 8:0 are m with the MSB first.
- R5: A rising edge of ser_load_i copies the shift register into the configuration. While ser_load_i is low, serial clocks shift the register but leave the configuration unchanged. The falling edge of ser_load_i therefore latches the values.
- R6: While ser_load_i is high, each serial clock rising edge copies the newly shifted register straight into the configuration.
- R7: In serial mode the test-select code drives test_o as follows: 00 gives low, 01 gives shift-register bit 16, 10 gives fb_div_i, and 11 gives bank_a_i.
- R8: In parallel mode test_o is low. Parallel mode holds from reset, and from any cycle where par_load_ni is low, until the next serial clock or serial load edge.
- R9: m_range_err_o is high exactly when m_o is below M_MIN or above M_MAX. An out-of-range value is still loaded.
- R10: While par_load_ni is low, serial clock and serial load edges are ignored. The shift register keeps its content and the configuration keeps following the pins.
- R11: If a serial clock rising edge and a serial load rising edge arrive in the same cycle, the configuration takes the register content that includes the new bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| par_load_ni | input | 1 | Parallel load strobe, active low: transparent while low, latches on rise |
| par_m_i | input | 9 | Parallel feedback divide value |
| par_na_i | input | 3 | Parallel bank A output divide code |
| par_nb_i | input | 3 | Parallel bank B output divide code |
| ser_clk_i | input | 1 | Serial shift clock (sampled) |
| ser_data_i | input | 1 | Serial data |
| ser_load_i | input | 1 | Serial load strobe |
| fb_div_i | input | 1 | Feedback divider output, for observation |
| bank_a_i | input | 1 | Bank A output, for observation |
| m_o | output | 9 | Active feedback divide value |
| na_o | output | 3 | Active bank A divide code |
| nb_o | output | 3 | Active bank B divide code |
| test_o | output | 1 | Test observation output |
| m_range_err_o | output | 1 | Feedback value outside [M_MIN, M_MAX] |

## Verification
Two serial actions can land in the same cycle: a serial clock edge and a serial load edge. The bench provokes this by raising both lines on the same clock. It then checks that the configuration holds the shift content with the new bit already appended.

A second collision happens when serial strobes toggle while the parallel strobe is low. The bench judges this case in two steps. First, the outputs must keep following the pins. Second, a later serial load must still deliver the shift content that existed before the parallel window.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  localparam int M_W  = 9;
  localparam int N_W  = 3;
  localparam int T_W  = 2;
  localparam int SR_W = T_W + 2 * N_W + M_W;

  // field order matches the serial bit order, first-in at the top
  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] nb;
    logic [N_W-1:0] na;
    logic [M_W-1:0] m;
  } cfg_t;

  typedef enum logic [1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SHIFT = 2'b01,
    TSEL_FB    = 2'b10,
    TSEL_BANKA = 2'b11
  } tsel_e;
endpackage

// File: rtl/dcl_sync.sv
module dcl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dcl_shift.sv
module dcl_shift #(
  parameter int W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         bit_i,
  output logic [W-1:0] sr_o,
  output logic [W-1:0] sr_next_o
);
  logic [W-1:0] sr_q;

  assign sr_next_o = {sr_q[W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '0;
    else if (shift_en_i) sr_q <= sr_next_o;
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/dcl_ctrl.sv
module dcl_ctrl
  import dcl_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  init_done_i,
  input  logic                  pl_i,
  input  logic                  sl_i,
  input  logic                  sl_rise_i,
  input  logic                  sc_rise_i,
  input  logic [M_W+2*N_W-1:0]  pins_i,
  input  logic [SR_W-1:0]       sr_i,
  input  logic [SR_W-1:0]       sr_next_i,
  output cfg_t                  cfg_o,
  output logic                  ser_mode_o
);
  cfg_t cfg_q;
  logic ser_mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      ser_mode_q <= 1'b0;
    end else if (!init_done_i || !pl_i) begin
      // start-up capture and parallel transparency share one path
      {cfg_q.nb, cfg_q.na, cfg_q.m} <= pins_i;
      ser_mode_q <= 1'b0;
    end else if (sl_i && sc_rise_i) begin
      cfg_q      <= cfg_t'(sr_next_i);
      ser_mode_q <= 1'b1;
    end else if (sl_rise_i) begin
      cfg_q      <= cfg_t'(sr_i);
      ser_mode_q <= 1'b1;
    end else if (sc_rise_i) begin
      ser_mode_q <= 1'b1;
    end
  end

  assign cfg_o      = cfg_q;
  assign ser_mode_o = ser_mode_q;
endmodule

// File: rtl/div_cfg_loader.sv
module div_cfg_loader
  import dcl_pkg::*;
#(
  parameter int M_MIN       = 23,
  parameter int M_MAX       = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           par_load_ni,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_na_i,
  input  logic [N_W-1:0] par_nb_i,
  input  logic           ser_clk_i,
  input  logic           ser_data_i,
  input  logic           ser_load_i,
  input  logic           fb_div_i,
  input  logic           bank_a_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] na_o,
  output logic [N_W-1:0] nb_o,
  output logic           test_o,
  output logic           m_range_err_o
);
  localparam int PIN_W  = M_W + 2 * N_W;
  localparam int SYNC_W = 4 + PIN_W;
  localparam int INIT_N = SYNC_STAGES + 1;
  localparam int CNT_W  = $clog2(INIT_N + 1);
  localparam logic [M_W-1:0] M_LO = M_W'(M_MIN);
  localparam logic [M_W-1:0] M_HI = M_W'(M_MAX);

  logic [SYNC_W-1:0] raw, syn;
  logic              pl_s, sl_s, sc_s, sd_s;
  logic [PIN_W-1:0]  pins_s;
  logic              sc_prev, sl_prev, sc_rise, sl_rise;
  logic [CNT_W-1:0]  init_cnt;
  logic              init_done;
  logic [SR_W-1:0]   sr_q, sr_next;
  cfg_t              cfg_q;
  logic              ser_mode;
  logic              test_sel;

  assign raw = {par_load_ni, ser_load_i, ser_clk_i, ser_data_i, par_nb_i, par_na_i, par_m_i};

  dcl_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (syn)
  );

  assign pl_s   = syn[SYNC_W-1];
  assign sl_s   = syn[SYNC_W-2];
  assign sc_s   = syn[SYNC_W-3];
  assign sd_s   = syn[SYNC_W-4];
  assign pins_s = syn[PIN_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_prev  <= 1'b0;
      sl_prev  <= 1'b0;
      init_cnt <= '0;
    end else begin
      sc_prev <= sc_s;
      sl_prev <= sl_s;
      if (!init_done) init_cnt <= init_cnt + 1'b1;
    end
  end

  assign init_done = (init_cnt == CNT_W'(INIT_N));
  assign sc_rise   = init_done & sc_s & ~sc_prev;
  assign sl_rise   = init_done & sl_s & ~sl_prev;

  dcl_shift #(.W(SR_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (pl_s & sc_rise),
    .bit_i      (sd_s),
    .sr_o       (sr_q),
    .sr_next_o  (sr_next)
  );

  dcl_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_done_i (init_done),
    .pl_i        (pl_s),
    .sl_i        (sl_s),
    .sl_rise_i   (sl_rise),
    .sc_rise_i   (sc_rise),
    .pins_i      (pins_s),
    .sr_i        (sr_q),
    .sr_next_i   (sr_next),
    .cfg_o       (cfg_q),
    .ser_mode_o  (ser_mode)
  );

  always_comb begin
    unique case (tsel_e'(cfg_q.t))
      TSEL_LOW:   test_sel = 1'b0;
      TSEL_SHIFT: test_sel = sr_q[SR_W-1];
      TSEL_FB:    test_sel = fb_div_i;
      TSEL_BANKA: test_sel = bank_a_i;
      default:    test_sel = 1'b0;
    endcase
  end

  assign test_o        = ser_mode & test_sel;
  assign m_o           = cfg_q.m;
  assign na_o          = cfg_q.na;
  assign nb_o          = cfg_q.nb;
  assign m_range_err_o = (cfg_q.m < M_LO) || (cfg_q.m > M_HI);
endmodule

// File: rtl/dcl_chk.sv
module dcl_chk
  import dcl_pkg::*;
#(
  parameter int M_MIN = 23,
  parameter int M_MAX = 30
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 init_done,
  input logic                 pl_s,
  input logic                 sl_s,
  input logic                 sd_s,
  input logic                 sc_rise,
  input logic [M_W+2*N_W-1:0] pins_s,
  input logic [SR_W-1:0]      sr_q,
  input logic [SR_W-1:0]      cfg_q,
  input logic                 ser_mode,
  input logic [M_W-1:0]       m_o,
  input logic                 test_o,
  input logic                 fb_div_i,
  input logic                 m_range_err_o
);
  // R2
  par_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done && !pl_s) |=> (cfg_q[M_W+2*N_W-1:0] == $past(pins_s)));

  // R4
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done && pl_s && sc_rise) |=> (sr_q[0] == $past(sd_s)));

  // R5
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done && pl_s && !sl_s) |=> $stable(cfg_q));

  // R6
  pass_thru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done && pl_s && sl_s && sc_rise) |=> (cfg_q == $past({sr_q[SR_W-2:0], sd_s})));

  // R7
  test_fb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_mode && cfg_q[SR_W-1 -: T_W] == 2'b10) |-> (test_o == fb_div_i));

  // R8
  test_par_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_mode |-> !test_o);

  // R9
  range_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_o >= M_W'(M_MIN) && m_o <= M_W'(M_MAX)) |-> !m_range_err_o);

  // R10
  par_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done && !pl_s) |=> (!ser_mode && $stable(sr_q)));
endmodule

bind div_cfg_loader dcl_chk #(.M_MIN(M_MIN), .M_MAX(M_MAX)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .init_done     (init_done),
  .pl_s          (pl_s),
  .sl_s          (sl_s),
  .sd_s          (sd_s),
  .sc_rise       (sc_rise),
  .pins_s        (pins_s),
  .sr_q          (sr_q),
  .cfg_q         (cfg_q),
  .ser_mode      (ser_mode),
  .m_o           (m_o),
  .test_o        (test_o),
  .fb_div_i      (fb_div_i),
  .m_range_err_o (m_range_err_o)
);

// File: tb/div_cfg_loader_tb.sv
module div_cfg_loader_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       par_load_ni = 1'b1;
  logic [8:0] par_m_i = '0;
  logic [2:0] par_na_i = '0;
  logic [2:0] par_nb_i = '0;
  logic       ser_clk_i = 1'b0;
  logic       ser_data_i = 1'b0;
  logic       ser_load_i = 1'b0;
  logic       fb_div_i = 1'b0;
  logic       bank_a_i = 1'b0;
  logic [8:0] m_o;
  logic [2:0] na_o, nb_o;
  logic       test_o, m_range_err_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [16:0] sr_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  div_cfg_loader u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .par_load_ni(par_load_ni),
    .par_m_i(par_m_i), .par_na_i(par_na_i), .par_nb_i(par_nb_i),
    .ser_clk_i(ser_clk_i), .ser_data_i(ser_data_i), .ser_load_i(ser_load_i),
    .fb_div_i(fb_div_i), .bank_a_i(bank_a_i),
    .m_o(m_o), .na_o(na_o), .nb_o(nb_o), .test_o(test_o), .m_range_err_o(m_range_err_o)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_cfg(string req, int m, int na, int nb);
    chk(req, m_o, m);
    chk(req, na_o, na);
    chk(req, nb_o, nb);
  endtask

  task automatic ser_bit(logic b);
    ser_data_i = b;
    ser_clk_i  = 1'b1;
    step(4);
    ser_clk_i  = 1'b0;
    step(4);
    if (par_load_ni) sr_m = {sr_m[15:0], b};
  endtask

  task automatic ser_word(logic [16:0] w);
    for (int i = 16; i >= 0; i--) ser_bit(w[i]);
  endtask

  task automatic sl_pulse();
    ser_load_i = 1'b1;
    step(5);
    ser_load_i = 1'b0;
    step(5);
  endtask

  task automatic t_reset();
    par_m_i = 9'd25; par_na_i = 3'd2; par_nb_i = 3'd5;
    step(3);
    rst_ni = 1'b1;
    step(6);
    chk_cfg("R1 pins at start-up", 25, 2, 5);
    chk("R1 test low", test_o, 0);
    chk("R9 in range", m_range_err_o, 0);
  endtask

  task automatic t_parallel();
    par_m_i = 9'd28; par_na_i = 3'd1; par_nb_i = 3'd3;
    par_load_ni = 1'b0;
    step(5);
    chk_cfg("R2 transparent", 28, 1, 3);
    chk("R8 test low in parallel", test_o, 0);
    par_m_i = 9'd40;
    step(5);
    chk("R2 follow", m_o, 40);
    chk("R9 above max", m_range_err_o, 1);
    par_m_i = 9'd22;
    step(5);
    chk("R9 below min", m_range_err_o, 1);
    par_m_i = 9'd23;
    step(5);
    chk("R9 at min", m_range_err_o, 0);
    par_load_ni = 1'b1;
    step(5);
    par_m_i = 9'd99; par_na_i = 3'd7; par_nb_i = 3'd0;
    step(5);
    chk_cfg("R3 latched", 23, 1, 3);
    chk("R8 test low after latch", test_o, 0);
  endtask

  task automatic t_serial_load();
    logic [16:0] w1, w2;
    w1 = {2'b10, 3'b110, 3'b011, 9'd30};
    w2 = {2'b11, 3'b001, 3'b100, 9'd300};
    ser_word(w1);
    chk("R5 shift leaves cfg", m_o, 23);
    ser_load_i = 1'b1;
    step(5);
    chk_cfg("R4 field order", 30, 3, 6);
    chk("R9 serial in range", m_range_err_o, 0);
    fb_div_i = 1'b1; step(1);
    chk("R7 code 10 high", test_o, 1);
    fb_div_i = 1'b0; step(1);
    chk("R7 code 10 low", test_o, 0);
    ser_load_i = 1'b0;
    step(5);
    ser_word(w2);
    chk_cfg("R5 latched on fall", 30, 3, 6);
    ser_load_i = 1'b1;
    step(5);
    chk_cfg("R5 rise transfers", 300, 4, 1);
    chk("R9 serial out of range", m_range_err_o, 1);
    bank_a_i = 1'b1; step(1);
    chk("R7 code 11 high", test_o, 1);
    bank_a_i = 1'b0; step(1);
    chk("R7 code 11 low", test_o, 0);
  endtask

  task automatic t_pass_through();
    ser_bit(1'b0);
    chk_cfg("R6 pass-through", sr_m[8:0], sr_m[11:9], sr_m[14:12]);
    ser_bit(1'b1);
    chk_cfg("R6 pass-through 2", sr_m[8:0], sr_m[11:9], sr_m[14:12]);
    ser_load_i = 1'b0;
    step(5);
  endtask

  task automatic t_shift_observe();
    logic [16:0] w3;
    w3 = {2'b01, 3'b010, 3'b101, 9'd27};
    ser_word(w3);
    sl_pulse();
    chk_cfg("R4 second word", 27, 5, 2);
    chk("R7 code 01 shows bit16", test_o, 0);
    ser_bit(1'b0);
    chk("R7 code 01 after shift", test_o, 1);
    chk("R5 shift keeps cfg", m_o, 27);
  endtask

  task automatic t_par_priority();
    logic [16:0] keep;
    keep = sr_m;
    par_m_i = 9'd26; par_na_i = 3'd4; par_nb_i = 3'd2;
    par_load_ni = 1'b0;
    step(5);
    chk("R8 test low on par low", test_o, 0);
    ser_bit(1'b1);
    ser_bit(1'b0);
    sl_pulse();
    chk_cfg("R10 serial ignored", 26, 4, 2);
    par_load_ni = 1'b1;
    step(5);
    par_m_i = 9'd5;
    step(5);
    chk("R3 latch after serial ignore", m_o, 26);
    ser_load_i = 1'b1;
    step(5);
    chk_cfg("R10 shift reg kept", keep[8:0], keep[11:9], keep[14:12]);
    ser_load_i = 1'b0;
    step(5);
  endtask

  task automatic t_collide();
    ser_data_i = 1'b1;
    ser_clk_i  = 1'b1;
    ser_load_i = 1'b1;
    step(5);
    sr_m = {sr_m[15:0], 1'b1};
    chk_cfg("R11 same-cycle edges", sr_m[8:0], sr_m[11:9], sr_m[14:12]);
    ser_clk_i  = 1'b0;
    ser_load_i = 1'b0;
    step(5);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_parallel();
        t_serial_load();
        t_pass_through();
        t_shift_observe();
        t_par_priority();
        t_collide();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule